// File: doc/BRIEF.md
# Two-to-five sample packing gearbox

This block sits directly behind the capture stage of a fast data converter. Each fast-clock cycle the capture stage presents two 12-bit samples: one taken on the rising edge of the interface clock and one on the falling edge. The converter produces one sample per nanosecond. The block regroups that stream into 60-bit words of five consecutive samples, so downstream processing can work on five samples at once at the slower 200 MHz system rate.

Two samples come in per cycle and five go out per word. Because 2:5 is not an integer ratio, every other word boundary falls between the two samples of an input pair. The block holds that leftover sample and places it first in the next word. A qualifier on the input lets the capture stage skip cycles. Skipped cycles do not advance the packing and never release a partial word. Words leave in the fast clock domain as single-cycle pulses. An external FIFO carries them into the system-clock domain.

Top module: `gb_pack_2to5`

## Requirements
- R1: Each output word holds five consecutive input samples, with no sample skipped or repeated: the earliest sample is in bits [11:0], the next in [23:12], and so on, and the latest is in bits [59:48].
- R2: Within an input pair, the sample on bits [11:0] of `in_pair` (rising-edge capture) comes before the sample on bits [23:12] (falling-edge capture) in the output order.
- R3: With `in_valid` held high, `word_valid` is high on exactly 2 of every 5 cycles. It is a single-cycle pulse and is never high on two consecutive cycles.
- R4: `word_valid` and the new `word_data` appear in the cycle after the clock edge that accepts the pair that completes the word.
- R5: In a cycle where `in_valid` is low, no sample is taken and the packing position does not move. In the following cycle `word_valid` is low and `word_data` is unchanged.
- R6: While `rst_n` is low, `word_valid` is low and `word_data` is zero. The first word after release is built from the first five samples accepted after release.
- R7: Between words the block keeps at most one unsent sample. A new word therefore completes within three accepted pairs of the previous one.
- R8: A reset asserted in the middle of a word discards the samples gathered so far. The first word after release starts with the first sample accepted after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast interface clock (one input pair per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | The pair on `in_pair` is to be taken this cycle |
| in_pair | input | 24 | [11:0] rising-edge sample, [23:12] falling-edge sample |
| word_valid | output | 1 | One-cycle pulse: `word_data` holds a new five-sample word |
| word_data | output | 60 | Five samples, earliest in [11:0], latest in [59:48] |

## Verification
The assertions check the rules that hold on every cycle. A word pulse always follows an accepted pair and is never followed by another pulse. A skipped input cycle leaves the word output, the pulse and the packing position unchanged. After a word is released, fewer than two samples are left behind. The bench compares the block with a sample-queue model and covers what a cycle-local property cannot see. That covers sample order and continuity across word boundaries that split a pair, the 2-in-5 pulse density over a long uninterrupted stream, and which samples the first word holds after a reset at power-up or in the middle of a word.

// File: rtl/gb_pkg.sv
package gb_pkg;
  localparam int unsigned GB_SAMPLE_W  = 12;
  localparam int unsigned GB_IN_LANES  = 2;
  localparam int unsigned GB_OUT_LANES = 5;
endpackage

// File: rtl/gb_accum.sv
// Holding buffer and packing position: merges the newly accepted lanes
// behind the held samples and releases a full word when enough are present.
module gb_accum #(
  parameter int unsigned W   = gb_pkg::GB_SAMPLE_W,
  parameter int unsigned IN  = gb_pkg::GB_IN_LANES,
  parameter int unsigned OUT = gb_pkg::GB_OUT_LANES,
  parameter int unsigned FW  = $clog2(OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN*W-1:0]   in_lanes,
  output logic              emit_o,
  output logic [OUT*W-1:0]  word_o,
  output logic [FW-1:0]     fill_o
);
  localparam int unsigned HOLD = OUT - 1;
  localparam int unsigned MRG  = HOLD + IN;

  logic [W-1:0]  lane    [IN];
  logic [W-1:0]  merged  [MRG];
  logic [W-1:0]  hold_q  [HOLD];
  logic [W-1:0]  hold_d  [HOLD];
  logic [FW-1:0] fill_q, fill_d;
  logic          emit;
  int            total;

  for (genvar j = 0; j < IN; j++) begin : g_lane
    assign lane[j] = in_lanes[j*W +: W];
  end

  // merged[k]: held sample if k is below the fill level, else incoming lane k-fill
  for (genvar k = 0; k < MRG; k++) begin : g_merge
    logic [W-1:0] m;
    if (k < HOLD) begin : g_held
      always_comb begin
        m = '0;
        for (int j = 0; j < IN; j++) begin
          if (k == int'(fill_q) + j) m = lane[j];
        end
        if (k < int'(fill_q)) m = hold_q[k];
      end
    end else begin : g_new
      always_comb begin
        m = '0;
        for (int j = 0; j < IN; j++) begin
          if (k == int'(fill_q) + j) m = lane[j];
        end
      end
    end
    assign merged[k] = m;
  end

  always_comb begin
    total  = int'(fill_q) + int'(IN);
    emit   = in_valid && (total >= int'(OUT));
    fill_d = fill_q;
    if (in_valid) begin
      if (emit) fill_d = FW'(total - int'(OUT));
      else      fill_d = FW'(total);
    end
  end

  for (genvar k = 0; k < HOLD; k++) begin : g_next
    if (k + OUT < MRG) begin : g_shift
      assign hold_d[k] = emit ? merged[k+OUT] : merged[k];
    end else begin : g_keep
      assign hold_d[k] = emit ? '0 : merged[k];
    end
  end

  for (genvar k = 0; k < OUT; k++) begin : g_word
    assign word_o[k*W +: W] = merged[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int k = 0; k < HOLD; k++) hold_q[k] <= '0;
    end else if (in_valid) begin
      fill_q <= fill_d;
      for (int k = 0; k < HOLD; k++) hold_q[k] <= hold_d[k];
    end
  end

  assign emit_o = emit;
  assign fill_o = fill_q;
endmodule

// File: rtl/gb_outreg.sv
// Output stage: one-cycle word pulse and a word register loaded on release.
module gb_outreg #(
  parameter int unsigned DW = gb_pkg::GB_SAMPLE_W * gb_pkg::GB_OUT_LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          valid_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= load;
      if (load) data_q <= din;
    end
  end
endmodule

// File: rtl/gb_pack_2to5.sv
module gb_pack_2to5 #(
  parameter int unsigned SAMPLE_W  = gb_pkg::GB_SAMPLE_W,
  parameter int unsigned IN_LANES  = gb_pkg::GB_IN_LANES,
  parameter int unsigned OUT_LANES = gb_pkg::GB_OUT_LANES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [IN_LANES*SAMPLE_W-1:0]  in_pair,
  output logic                          word_valid,
  output logic [OUT_LANES*SAMPLE_W-1:0] word_data
);
  localparam int unsigned FILL_W = $clog2(OUT_LANES);
  localparam int unsigned WORD_W = OUT_LANES * SAMPLE_W;

  logic              emit;
  logic [WORD_W-1:0] word_next;
  logic [FILL_W-1:0] fill_mon;

  gb_accum #(
    .W(SAMPLE_W), .IN(IN_LANES), .OUT(OUT_LANES), .FW(FILL_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_pair),
    .emit_o(emit), .word_o(word_next), .fill_o(fill_mon)
  );

  gb_outreg #(.DW(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .din(word_next),
    .valid_q(word_valid), .data_q(word_data)
  );
endmodule

// File: rtl/gb_pack_chk.sv
module gb_pack_chk #(
  parameter int unsigned W   = 12,
  parameter int unsigned IN  = 2,
  parameter int unsigned OUT = 5,
  parameter int unsigned FW  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             word_valid,
  input logic [OUT*W-1:0] word_data,
  input logic [FW-1:0]    fill
);
  // R4: a word pulse only follows an edge that accepted a pair
  assert_pulse_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(in_valid));

  // R3: the word pulse lasts one cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R5: a skipped cycle releases nothing and leaves the word unchanged
  assert_stall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!word_valid && $stable(word_data)));

  // R5: a skipped cycle does not move the packing position
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(fill));

  // R7: after a word leaves, fewer than one pair of samples remains
  assert_residue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (int'(fill) < int'(IN)));
endmodule

bind gb_pack_2to5 gb_pack_chk #(
  .W(SAMPLE_W), .IN(IN_LANES), .OUT(OUT_LANES), .FW(FILL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .word_valid(word_valid), .word_data(word_data), .fill(fill_mon)
);

// File: tb/tb_gb_pack_2to5.sv
module tb_gb_pack_2to5;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_pair;
  logic        word_valid;
  logic [59:0] word_data;

  gb_pack_2to5 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pair(in_pair),
    .word_valid(word_valid), .word_data(word_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  logic [11:0] q[$];
  logic        exp_valid;
  logic [59:0] exp_data;
  logic [11:0] seq;
  int          pairs_since;
  int          words_seen;
  logic        prev_wv;
  string       tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare outputs with the model, then drive one cycle and advance the model.
  task automatic step(input bit v, input logic [11:0] r, input logic [11:0] f);
    @(negedge clk);
    chk(word_valid === exp_valid, tag, "word_valid", 64'(word_valid), 64'(exp_valid));
    chk(word_data === exp_data, tag, "word_data", 64'(word_data), 64'(exp_data));
    chk(!(prev_wv && word_valid), "R3", "back-to-back pulse", 64'(word_valid), 64'(0));
    if (word_valid) begin
      words_seen++;
      chk(pairs_since <= 3, "R7", "pairs per word", 64'(pairs_since), 64'(3));
      pairs_since = 0;
    end
    prev_wv  = word_valid;
    in_valid = v;
    in_pair  = {f, r};
    if (v) begin
      pairs_since++;
      q.push_back(r);
      q.push_back(f);
    end
    if (q.size() >= 5) begin
      for (int k = 0; k < 5; k++) exp_data[k*12 +: 12] = q.pop_front();
      exp_valid = 1'b1;
    end else begin
      exp_valid = 1'b0;
    end
  endtask

  task automatic seq_step(input bit v);
    step(v, seq, seq + 12'd1);
    if (v) seq = seq + 12'd2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    q.delete(); exp_valid = 1'b0; exp_data = '0;
    pairs_since = 0; prev_wv = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(word_valid === 1'b0, "R6", "valid in reset", 64'(word_valid), 64'(0));
      chk(word_data === '0, "R6", "data in reset", 64'(word_data), 64'(0));
    end
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pair = '0;
    exp_valid = 1'b0; exp_data = '0; pairs_since = 0; prev_wv = 1'b0;
    words_seen = 0; seq = 12'd0; tag = "R6";
    do_reset();

    // R2: rising-edge lane precedes falling-edge lane
    tag = "R2";
    step(1'b1, 12'h100, 12'h200);
    step(1'b1, 12'h101, 12'h201);
    step(1'b1, 12'h102, 12'h202);
    step(1'b0, 12'h000, 12'h000);
    chk(word_valid && word_data[11:0] == 12'h100 && word_data[23:12] == 12'h200,
        "R2", "lane order", 64'(word_data[23:0]), 64'h200100);

    // R3 R4 R1: long uninterrupted stream from reset, 2-in-5 pulse density
    do_reset();
    tag = "R4"; seq = 12'hF80; words_seen = 0;
    for (int i = 0; i < 50; i++) seq_step(1'b1);
    seq_step(1'b0);
    chk(words_seen == 20, "R3", "words per 50 pairs", 64'(words_seen), 64'd20);

    // R5 R1: irregular stalls, including a long gap inside a word
    tag = "R5";
    for (int i = 0; i < 60; i++) seq_step((i % 3) != 0);
    seq_step(1'b1);
    for (int i = 0; i < 10; i++) seq_step(1'b0);
    for (int i = 0; i < 12; i++) seq_step(1'b1);
    for (int i = 0; i < 3; i++) seq_step(1'b0);

    // R8: reset in the middle of a word discards the partial samples
    seq_step(1'b1); seq_step(1'b1);
    do_reset();
    tag = "R8"; seq = 12'h7A0; words_seen = 0;
    for (int i = 0; i < 3; i++) seq_step(1'b1);
    seq_step(1'b0);
    chk(word_valid && word_data[11:0] == 12'h7A0, "R8", "first word after reset",
        64'(word_data[11:0]), 64'h7A0);

    // R1: word continuity across the split pair boundary
    tag = "R1";
    for (int i = 0; i < 20; i++) begin
      seq_step(1'b1);
      if (word_valid) begin
        for (int k = 0; k < 4; k++)
          chk(word_data[(k+1)*12 +: 12] == word_data[k*12 +: 12] + 12'd1, "R1",
              "consecutive lanes", 64'(word_data[(k+1)*12 +: 12]),
              64'(word_data[k*12 +: 12] + 12'd1));
      end
    end
    for (int i = 0; i < 3; i++) seq_step(1'b0);
    summary();
  end
endmodule